// File: doc/BRIEF.md
# SPI Controller Status Flags and Interrupt

This block holds the status word of a serial-peripheral controller and drives its single level-sensitive interrupt line. Four of the flags mirror the current levels of the transmit and receive FIFOs, registered once. Two flags are sticky event flags: receive overflow and transfer complete. Software clears each of them by writing a one to its bit of the status register. The interrupt line goes high, one clock later, when any status bit is set together with the matching bit of a 32-bit enable word.

The FIFOs and the shift engine sit outside this block. They report to it through level inputs (empty, full) and event inputs. The event inputs are: a received word that is ready to be stored, the end of a transfer, and a flush of either FIFO. For each received word, the block also decides whether the word may enter the receive FIFO. A word that arrives while the FIFO is full is refused and raises the overflow flag.

Top module: `spi_stat_irq`

## Requirements
- R1: While reset is asserted, `status_o` reads 0x00000003 and `irq_o` is low. After reset, every flag is recomputed on each clock edge.
- R2: Bit 0 is set when `tx_empty_i` was high at the previous clock edge, and bit 1 is set when `tx_full_i` was high at that edge.
- R3: Bit 2 is set when `rx_empty_i` was low at the previous clock edge, and bit 3 is set when `rx_full_i` was high at that edge.
- R4: Bit 4 (overflow) is set on the edge where `rx_word_i` is high and `rx_full_i` is high. It then stays set until it is cleared by a write or by a receive flush.
- R5: `rx_store_o` is high exactly when `rx_word_i` is high and `rx_full_i` is low, in the same cycle. A word that arrives while the receive FIFO is full is dropped.
- R6: Bit 5 (transfer complete) is set on the edge where `xfer_done_i` is high, and stays set until it is cleared by a write.
- R7: On an edge where `stat_wr_i` is high, a one in `stat_wdata_i` bit 4 or bit 5 clears that sticky bit. Every other written bit is ignored, and bits 31 down to 6 always read zero.
- R8: When a clearing write and a new event for the same sticky bit fall on the same edge, the bit ends up set.
- R9: `irq_o` equals the OR over all bits of `status_o & irq_en_i` as it was one clock earlier.
- R10: On an edge where `rx_flush_i` is high, bits 2, 3 and 4 are cleared. This overrides the FIFO level inputs and any overflow event in that cycle.
- R11: On an edge where `tx_flush_i` is high, bit 0 is set and bit 1 is cleared, whatever the transmit level inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_empty_i | input | 1 | Transmit FIFO holds no entries |
| tx_full_i | input | 1 | Transmit FIFO is full |
| rx_empty_i | input | 1 | Receive FIFO holds no entries |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_word_i | input | 1 | A received word is ready to be stored |
| xfer_done_i | input | 1 | Transfer-complete event, one cycle |
| rx_flush_i | input | 1 | Receive FIFO is being reset |
| tx_flush_i | input | 1 | Transmit FIFO is being reset |
| irq_en_i | input | STAT_W | Interrupt enable, one bit per status bit |
| stat_wr_i | input | 1 | Bus write strobe to the status register |
| stat_wdata_i | input | STAT_W | Bus write data |
| status_o | output | STAT_W | Status word |
| rx_store_o | output | 1 | Received word may enter the receive FIFO |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its default 32-bit status width, which holds six live flags. The nine one-bit control inputs give 512 input patterns per cycle. The bench walks through all of them, once for each of the four combinations of the two clearing bits in the write data. Because it walks them in sequence, every pattern meets the sticky bits both set and clear, so collisions between a write and an event, and between a flush and an event, all occur. The enable word rotates across the flag positions and sometimes floods the unused upper bits, so the interrupt is checked against each flag on its own.

// File: rtl/spi_stat_irq.sv
module spi_stat_irq #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  input  logic              rx_word_i,
  input  logic              xfer_done_i,
  input  logic              rx_flush_i,
  input  logic              tx_flush_i,
  input  logic [STAT_W-1:0] irq_en_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic              rx_store_o,
  output logic              irq_o
);

  localparam int FLAG_N = 6;
  localparam int B_TE   = 0;
  localparam int B_TF   = 1;
  localparam int B_RR   = 2;
  localparam int B_RF   = 3;
  localparam int B_OVF  = 4;
  localparam int B_DONE = 5;
  localparam logic [FLAG_N-1:0] RST_FLAGS = FLAG_N'(3);

  logic [FLAG_N-1:0] flags_q, flags_d;
  logic              irq_q;
  logic              ovf_ev, clr_ovf, clr_done;
  logic              unused_wdata;

  assign unused_wdata = ^stat_wdata_i;

  assign ovf_ev   = rx_word_i & rx_full_i;
  assign clr_ovf  = stat_wr_i & stat_wdata_i[B_OVF];
  assign clr_done = stat_wr_i & stat_wdata_i[B_DONE];

  assign flags_d[B_TE]   = tx_flush_i | tx_empty_i;
  assign flags_d[B_TF]   = ~tx_flush_i & tx_full_i;
  assign flags_d[B_RR]   = ~rx_flush_i & ~rx_empty_i;
  assign flags_d[B_RF]   = ~rx_flush_i & rx_full_i;
  assign flags_d[B_OVF]  = ~rx_flush_i & (ovf_ev | (flags_q[B_OVF] & ~clr_ovf));
  assign flags_d[B_DONE] = xfer_done_i | (flags_q[B_DONE] & ~clr_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= RST_FLAGS;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |(status_o & irq_en_i);
    end
  end

  assign status_o   = STAT_W'(flags_q);
  assign rx_store_o = rx_word_i & ~rx_full_i;
  assign irq_o      = irq_q;

  a_r4_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_i && rx_full_i && !rx_flush_i) |=> status_o[B_OVF]);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[B_OVF] && !(stat_wr_i && stat_wdata_i[B_OVF]) && !rx_flush_i) |=> status_o[B_OVF]);

  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> status_o[B_DONE]);

  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_store_o |-> (rx_word_i && !rx_full_i));

  a_r10_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_i |=> (!status_o[B_RR] && !status_o[B_RF] && !status_o[B_OVF]));

  a_r11_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_i |=> (status_o[B_TE] && !status_o[B_TF]));

  a_r9_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == |($past(status_o & irq_en_i))));

endmodule

// File: tb/spi_stat_irq_bench.sv
module spi_stat_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_e = 1'b1, tx_f = 1'b0, rx_e = 1'b1, rx_f = 1'b0;
  logic word = 1'b0, done = 1'b0, rxfl = 1'b0, txfl = 1'b0, wr = 1'b0;
  logic [W-1:0] en = '0, wd = '0;
  logic [W-1:0] status;
  logic store, irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] exp_f;
  logic       exp_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_stat_irq #(.STAT_W(W)) u_spi_stat_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_empty_i(tx_e), .tx_full_i(tx_f), .rx_empty_i(rx_e), .rx_full_i(rx_f),
    .rx_word_i(word), .xfer_done_i(done), .rx_flush_i(rxfl), .tx_flush_i(txfl),
    .irq_en_i(en), .stat_wr_i(wr), .stat_wdata_i(wd),
    .status_o(status), .rx_store_o(store), .irq_o(irq)
  );

  task automatic check(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0 (run hung)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset value
    check(status == 32'h3, "R1 status", status, 32'h3);
    check(irq == 1'b0, "R1 irq", W'(irq), '0);
    rst_n = 1'b1;
    exp_f = 6'b000011;
    exp_irq = 1'b0;
    for (int i = 0; i < 2048; i++) begin
      logic [10:0] b;
      logic [5:0] nf;
      b = i[10:0];
      tx_e = b[0]; tx_f = b[1]; rx_e = b[2]; rx_f = b[3];
      word = b[4]; done = b[5]; wr = b[6]; rxfl = b[7]; txfl = b[8];
      wd = {26'h3FF_FFFF, b[10], b[9], 4'hF};
      en = (W'(1) << (i % 6)) | ((i % 7 == 3) ? 32'hFFFF_FFC0 : 32'h0);
      #1;
      // R5: word accepted only when there is room
      check(store == (word & ~rx_f), "R5 store", W'(store), W'(word & ~rx_f));
      exp_irq = |({26'h0, exp_f} & en);
      nf[0] = txfl | tx_e;
      nf[1] = ~txfl & tx_f;
      nf[2] = ~rxfl & ~rx_e;
      nf[3] = ~rxfl & rx_f;
      nf[4] = ~rxfl & ((word & rx_f) | (exp_f[4] & ~(wr & wd[4])));
      nf[5] = done | (exp_f[5] & ~(wr & wd[5]));
      exp_f = nf;
      @(negedge clk);
      check(status[1:0] == exp_f[1:0], txfl ? "R11 tx flush" : "R2 tx flags",
            W'(status[1:0]), W'(exp_f[1:0]));
      check(status[3:2] == exp_f[3:2], rxfl ? "R10 rx flush" : "R3 rx flags",
            W'(status[3:2]), W'(exp_f[3:2]));
      check(status[4] == exp_f[4],
            rxfl ? "R10 ovf flush" : ((wr && word && rx_f) ? "R8 ovf collide" : "R4 ovf"),
            W'(status[4]), W'(exp_f[4]));
      check(status[5] == exp_f[5], (wr && done) ? "R8 done collide" : "R6 done",
            W'(status[5]), W'(exp_f[5]));
      check(status[W-1:6] == '0, "R7 upper zero", status, W'(exp_f));
      check(irq == exp_irq, "R9 irq", W'(irq), W'(exp_irq));
    end
    finish_run();
  end
endmodule